// File: doc/BRIEF.md
# SRAM Command Turnaround Scheduler

This block sits on the controller side of a burst-of-two, common-I/O SRAM. It takes read and write requests from a valid/ready interface and drives one registered command per clock. A command is an LD/R-W pin pair plus a pair address. The address is one bit narrower than the word index because every access moves two data beats. The shared data bus must settle and its termination must change whenever traffic switches direction. For that reason the scheduler puts a fixed run of idle commands between a write and a read, and between a read and a write.

An idle cycle has two forms. The read-flavoured no-op keeps termination off. The write-flavoured no-op keeps termination on. The length of each run depends on the direction of the switch and on the configured read latency, which is 2 or 3 cycles. While the scheduler inserts idle cycles it holds off the requester and keeps requests in their arrival order. When no request is waiting, it repeats the no-op type that matches the last bus direction.

Top module: `sram_turn_sched`

## Requirements
- R1: While reset is high, and on the first output cycle after reset, the command is a write-type no-op (cmd_ld=1, cmd_rw=0). The scheduler starts in the write direction.
- R2: An accepted read appears on the command pins in the clock after the handshake as cmd_ld=0, cmd_rw=1. cmd_addr equals the request's pair address.
- R3: An accepted write appears in the clock after the handshake as cmd_ld=0, cmd_rw=0. cmd_addr equals the request's pair address.
- R4: Requests in the same direction as the last issued access are accepted on consecutive cycles and issued back to back in arrival order, with no idle cycle between them.
- R5: With latency select 0 (latency 2), a read that follows write traffic is preceded by exactly two read-type no-ops (cmd_ld=1, cmd_rw=1) and no write-type no-op.
- R6: With latency select 1 (latency 3), a read that follows write traffic is preceded by exactly one read-type no-op.
- R7: With latency select 0, a write that follows read traffic is preceded by two read-type no-ops and then three write-type no-ops.
- R8: With latency select 1, a write that follows read traffic is preceded by three read-type no-ops and then three write-type no-ops.
- R9: With no request valid and no turnaround in progress, the scheduler issues a read-type no-op if the bus direction is read and a write-type no-op if it is write.
- R10: The cycle after a read command always carries cmd_rw=1 (a read or a read-type no-op).
- R11: req_ready is low during every cycle in which an inserted idle command is being decided, so no request is consumed during a turnaround.
- R12: The latency select is sampled in the cycle a turnaround starts. A change during the turnaround does not change that turnaround's idle counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat3_sel | input | 1 | Read latency select: 0 = 2 cycles, 1 = 3 cycles |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_is_rd | input | 1 | Request direction: 1 = read, 0 = write |
| req_addr | input | PAIR_AW | Pair (two-beat) address of the request |
| cmd_ld | output | 1 | Registered LD pin: 0 = access, 1 = no-op |
| cmd_rw | output | 1 | Registered R/W pin: 1 = read side, 0 = write side |
| cmd_addr | output | PAIR_AW | Registered address pin bus |

## Verification
The bench builds the scheduler with a 6-bit pair address and the default idle-run counts for both latency settings. The short address lets random requests reuse and alias addresses. The real gap tables are exercised as they are, so every direction switch under both latencies comes up many times. A latency flip in the middle of a turnaround is forced once. Random traffic also toggles latency between requests and mixes idle gaps with same-direction bursts, which reaches turnarounds that begin right after idle periods and back-to-back switches.

// File: rtl/sts_pkg.sv
package sts_pkg;
  // Pin pair encoding: bit 1 = LD, bit 0 = R/W
  typedef enum logic [1:0] {
    CMD_WR   = 2'b00,
    CMD_RD   = 2'b01,
    CMD_NOPW = 2'b10,
    CMD_NOPR = 2'b11
  } cmd_e;

  function automatic cmd_e nop_for(input logic rd);
    return rd ? CMD_NOPR : CMD_NOPW;
  endfunction

  function automatic cmd_e access_for(input logic rd);
    return rd ? CMD_RD : CMD_WR;
  endfunction
endpackage

// File: rtl/sts_gap_table.sv
module sts_gap_table #(
  parameter int CNT_W       = 3,
  parameter int L2_W2R_NOPW = 0,
  parameter int L2_W2R_NOPR = 2,
  parameter int L2_R2W_NOPR = 2,
  parameter int L2_R2W_NOPW = 3,
  parameter int L3_W2R_NOPW = 0,
  parameter int L3_W2R_NOPR = 1,
  parameter int L3_R2W_NOPR = 3,
  parameter int L3_R2W_NOPW = 3
) (
  input  logic             old_rd,
  input  logic             lat3,
  output logic [CNT_W-1:0] n_old,
  output logic [CNT_W-1:0] n_new
);
  // First run uses the no-op type of the old direction, second run the new one
  always_comb begin
    if (old_rd) begin
      n_old = lat3 ? CNT_W'(L3_R2W_NOPR) : CNT_W'(L2_R2W_NOPR);
      n_new = lat3 ? CNT_W'(L3_R2W_NOPW) : CNT_W'(L2_R2W_NOPW);
    end else begin
      n_old = lat3 ? CNT_W'(L3_W2R_NOPW) : CNT_W'(L2_W2R_NOPW);
      n_new = lat3 ? CNT_W'(L3_W2R_NOPR) : CNT_W'(L2_W2R_NOPR);
    end
  end
endmodule

// File: rtl/sts_turn_ctrl.sv
module sts_turn_ctrl
  import sts_pkg::*;
#(
  parameter int PAIR_AW     = 20,
  parameter int CNT_W       = 3,
  parameter int L2_W2R_NOPW = 0,
  parameter int L2_W2R_NOPR = 2,
  parameter int L2_R2W_NOPR = 2,
  parameter int L2_R2W_NOPW = 3,
  parameter int L3_W2R_NOPW = 0,
  parameter int L3_W2R_NOPR = 1,
  parameter int L3_R2W_NOPR = 3,
  parameter int L3_R2W_NOPW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lat3,
  input  logic               req_valid,
  input  logic               req_is_rd,
  input  logic [PAIR_AW-1:0] req_addr,
  output logic               req_ready,
  output cmd_e               nxt_cmd,
  output logic [PAIR_AW-1:0] nxt_addr,
  output logic               nxt_addr_en
);
  logic             dir_rd, tgt_rd;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic [CNT_W-1:0] g_old, g_new;
  logic [CNT_W-1:0] eff_a, eff_b, n_a, n_b;
  logic             eff_tgt, n_dir, n_tgt;
  logic             busy, mismatch, issue;

  sts_gap_table #(
    .CNT_W(CNT_W),
    .L2_W2R_NOPW(L2_W2R_NOPW), .L2_W2R_NOPR(L2_W2R_NOPR),
    .L2_R2W_NOPR(L2_R2W_NOPR), .L2_R2W_NOPW(L2_R2W_NOPW),
    .L3_W2R_NOPW(L3_W2R_NOPW), .L3_W2R_NOPR(L3_W2R_NOPR),
    .L3_R2W_NOPR(L3_R2W_NOPR), .L3_R2W_NOPW(L3_R2W_NOPW)
  ) gap_i (
    .old_rd(dir_rd),
    .lat3  (lat3),
    .n_old (g_old),
    .n_new (g_new)
  );

  assign busy      = (cnt_a != '0) || (cnt_b != '0);
  assign mismatch  = !busy && req_valid && (req_is_rd != dir_rd);
  assign eff_a     = busy ? cnt_a : (mismatch ? g_old : '0);
  assign eff_b     = busy ? cnt_b : (mismatch ? g_new : '0);
  assign eff_tgt   = busy ? tgt_rd : req_is_rd;
  assign req_ready = !busy && (!mismatch || ((g_old == '0) && (g_new == '0)));
  assign issue     = req_valid && req_ready;

  always_comb begin
    nxt_cmd     = nop_for(dir_rd);
    nxt_addr    = req_addr;
    nxt_addr_en = 1'b0;
    n_dir       = dir_rd;
    n_tgt       = tgt_rd;
    n_a         = '0;
    n_b         = '0;
    if (eff_a != '0) begin
      nxt_cmd = nop_for(dir_rd);
      n_a     = eff_a - CNT_W'(1);
      n_b     = eff_b;
      n_tgt   = eff_tgt;
    end else if (eff_b != '0) begin
      nxt_cmd = nop_for(eff_tgt);
      n_dir   = eff_tgt;
      n_b     = eff_b - CNT_W'(1);
      n_tgt   = eff_tgt;
    end else if (issue) begin
      nxt_cmd     = access_for(req_is_rd);
      nxt_addr_en = 1'b1;
      n_dir       = req_is_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_rd <= 1'b0;
      tgt_rd <= 1'b0;
      cnt_a  <= '0;
      cnt_b  <= '0;
    end else begin
      dir_rd <= n_dir;
      tgt_rd <= n_tgt;
      cnt_a  <= n_a;
      cnt_b  <= n_b;
    end
  end

  // R11
  ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  // R11
  no_issue_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !nxt_addr_en);
endmodule

// File: rtl/sts_cmd_reg.sv
module sts_cmd_reg
  import sts_pkg::*;
#(
  parameter int PAIR_AW = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  cmd_e               nxt_cmd,
  input  logic [PAIR_AW-1:0] nxt_addr,
  input  logic               nxt_addr_en,
  output logic               cmd_ld,
  output logic               cmd_rw,
  output logic [PAIR_AW-1:0] cmd_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ld   <= 1'b1;
      cmd_rw   <= 1'b0;
      cmd_addr <= '0;
    end else begin
      {cmd_ld, cmd_rw} <= nxt_cmd;
      if (nxt_addr_en) cmd_addr <= nxt_addr;
    end
  end
endmodule

// File: rtl/sram_turn_sched.sv
module sram_turn_sched
  import sts_pkg::*;
#(
  parameter int PAIR_AW     = 20,
  parameter int CNT_W       = 3,
  parameter int L2_W2R_NOPW = 0,
  parameter int L2_W2R_NOPR = 2,
  parameter int L2_R2W_NOPR = 2,
  parameter int L2_R2W_NOPW = 3,
  parameter int L3_W2R_NOPW = 0,
  parameter int L3_W2R_NOPR = 1,
  parameter int L3_R2W_NOPR = 3,
  parameter int L3_R2W_NOPW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lat3_sel,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_is_rd,
  input  logic [PAIR_AW-1:0] req_addr,
  output logic               cmd_ld,
  output logic               cmd_rw,
  output logic [PAIR_AW-1:0] cmd_addr
);
  cmd_e               nxt_cmd;
  logic [PAIR_AW-1:0] nxt_addr;
  logic               nxt_addr_en;

  sts_turn_ctrl #(
    .PAIR_AW(PAIR_AW), .CNT_W(CNT_W),
    .L2_W2R_NOPW(L2_W2R_NOPW), .L2_W2R_NOPR(L2_W2R_NOPR),
    .L2_R2W_NOPR(L2_R2W_NOPR), .L2_R2W_NOPW(L2_R2W_NOPW),
    .L3_W2R_NOPW(L3_W2R_NOPW), .L3_W2R_NOPR(L3_W2R_NOPR),
    .L3_R2W_NOPR(L3_R2W_NOPR), .L3_R2W_NOPW(L3_R2W_NOPW)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .lat3       (lat3_sel),
    .req_valid  (req_valid),
    .req_is_rd  (req_is_rd),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .nxt_cmd    (nxt_cmd),
    .nxt_addr   (nxt_addr),
    .nxt_addr_en(nxt_addr_en)
  );

  sts_cmd_reg #(.PAIR_AW(PAIR_AW)) out_i (
    .clk        (clk),
    .rst        (rst),
    .nxt_cmd    (nxt_cmd),
    .nxt_addr   (nxt_addr),
    .nxt_addr_en(nxt_addr_en),
    .cmd_ld     (cmd_ld),
    .cmd_rw     (cmd_rw),
    .cmd_addr   (cmd_addr)
  );

  // R10
  rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ld && cmd_rw) |=> cmd_rw);

  // R2
  issue_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!cmd_ld && (cmd_rw == $past(req_is_rd))));

  // R3
  issue_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd_addr == $past(req_addr)));

  // R5
  wr2rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ld && cmd_rw) |-> !$past(!cmd_ld && !cmd_rw));

  // R7
  rd2wr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ld && !cmd_rw) |-> (!$past(!cmd_ld && cmd_rw, 1) && !$past(!cmd_ld && cmd_rw, 2)));
endmodule

// File: tb/sram_turn_sched_tb.sv
module sram_turn_sched_tb_top;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lat3_sel = 1'b0;
  logic req_valid = 1'b0;
  logic req_is_rd = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, cmd_ld, cmd_rw;
  logic [AW-1:0] cmd_addr;

  sram_turn_sched #(.PAIR_AW(AW)) dut_i (
    .clk(clk), .rst(rst), .lat3_sel(lat3_sel),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_is_rd(req_is_rd), .req_addr(req_addr),
    .cmd_ld(cmd_ld), .cmd_rw(cmd_rw), .cmd_addr(cmd_addr)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit have_exp = 1'b0;
  logic e_ld, e_rw;
  logic [AW-1:0] e_addr;
  string e_tag = "R1";
  string force_tag = "";
  bit lat_drv = 1'b0;
  bit prev_rd = 1'b0;
  bit m_dir = 1'b0, m_old = 1'b0, m_new = 1'b0, m_lat = 1'b0;
  int m_pos = -1, m_a = 0, m_b = 0;
  bit last_rd = 1'b0;

  // Idle run lengths from the requirements (R5..R8)
  function automatic int gap_old(bit old_rd, bit l3);
    return old_rd ? (l3 ? 3 : 2) : 0;
  endfunction
  function automatic int gap_new(bit old_rd, bit l3);
    return old_rd ? 3 : (l3 ? 1 : 2);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit v, input bit rd, input logic [AW-1:0] a, output bit acc);
    string t;
    bit rdy;
    @(negedge clk);
    if (have_exp) begin
      check(e_tag, {30'd0, cmd_ld, cmd_rw}, {30'd0, e_ld, e_rw});
      if (!e_ld) check(e_tag, 32'(cmd_addr), 32'(e_addr));
    end
    if (prev_rd) check("R10", 32'(cmd_rw), 32'd1);
    prev_rd = (cmd_ld === 1'b0) && (cmd_rw === 1'b1);
    req_valid = v; req_is_rd = rd; req_addr = a; lat3_sel = lat_drv;
    #1;
    rdy = 1'b0;
    if (m_pos < 0 && v && rd != m_dir) begin
      m_a = gap_old(m_dir, lat_drv); m_b = gap_new(m_dir, lat_drv);
      m_old = m_dir; m_new = rd; m_lat = lat_drv; m_pos = 0;
    end
    if (m_pos >= 0 && m_pos < m_a + m_b) begin
      e_ld = 1'b1;
      e_rw = (m_pos < m_a) ? m_old : m_new;
      t = m_old ? (m_lat ? "R8" : "R7") : (m_lat ? "R6" : "R5");
      m_pos++;
      if (m_pos == m_a + m_b) begin m_dir = m_new; m_pos = -1; end
    end else begin
      if (m_pos >= 0) begin m_dir = m_new; m_pos = -1; end
      if (v) begin
        rdy = 1'b1; e_ld = 1'b0; e_rw = rd; e_addr = a; m_dir = rd;
        t = rd ? "R2" : "R3";
      end else begin
        e_ld = 1'b1; e_rw = m_dir; t = "R9";
      end
    end
    if (force_tag != "") t = force_tag;
    e_tag = t;
    have_exp = 1'b1;
    if (v) check(rdy ? t : "R11", 32'(req_ready), 32'(rdy));
    acc = v && rdy;
  endtask

  task automatic run_req(input bit rd, input logic [AW-1:0] a);
    bit acc;
    do cyc(1'b1, rd, a, acc); while (!acc);
    last_rd = rd;
  endtask

  task automatic run_idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, acc);
  endtask

  initial begin
    bit acc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", {30'd0, cmd_ld, cmd_rw}, 32'b10);
    rst = 1'b0;
    e_ld = 1'b1; e_rw = 1'b0; e_tag = "R1"; have_exp = 1'b1;
    force_tag = "R1"; run_idle(1); force_tag = "";
    run_idle(2);                               // R9 write idle
    force_tag = "R4";
    run_req(1'b0, 6'd1); run_req(1'b0, 6'd2); run_req(1'b0, 6'd3);
    force_tag = "";
    run_req(1'b1, 6'd10);                      // R5 then R2
    force_tag = "R4";
    run_req(1'b1, 6'd11); run_req(1'b1, 6'd12); run_req(1'b1, 6'd13);
    force_tag = "";
    run_idle(3);                               // R9 read idle
    run_req(1'b0, 6'd20);                      // R7
    lat_drv = 1'b1;
    run_req(1'b1, 6'd21);                      // R6
    run_req(1'b0, 6'd22);                      // R8
    run_idle(2);
    // R12: latency flips in the middle of a turnaround
    lat_drv = 1'b0;
    run_req(1'b1, 6'd30);
    cyc(1'b1, 1'b0, 6'd31, acc);
    lat_drv = 1'b1; force_tag = "R12";
    run_req(1'b0, 6'd31);
    force_tag = "";
    run_idle(1);
    // random traffic
    for (int i = 0; i < 1500; i++) begin
      bit rd;
      if ($urandom % 4 == 0) run_idle(1 + int'($urandom % 3));
      if ($urandom % 8 == 0) lat_drv = ~lat_drv;
      rd = ($urandom % 4 == 0) ? ~last_rd : last_rd;
      run_req(rd, AW'($urandom));
    end
    run_idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule